// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block holds a programmable alarm time and compares it against the live clock-calendar fields: second, minute, hour, day of month, month and weekday. Every alarm field has its own enable bit. A disabled field counts as "don't care", so one comparator covers several kinds of alarm. An alarm can fire once a minute (only the seconds field enabled), on every given weekday (only the weekday field enabled), or at one exact moment (all fields enabled).

The comparison is made only on the cycle where the seconds-tick strobe is high. When every enabled field matches, a sticky status flag is set. The flag stays set until the host clears it with a write-one-to-clear strobe. The host programs the alarm through a small write port: one address per alarm field and one address for the enable mask.

Top module: `alm_match_top`

## Requirements
- R1: After synchronous reset, `alarm_flag` is 0, all six alarm field values are 0 and all six enable bits are 0.
- R2: On a cycle with `tick` = 1, if every enabled field equals the matching live field, `alarm_flag` reads 1 from the next cycle on.
- R3: Fields whose enable bit is 0 have no effect on the match. With only the seconds field enabled, the flag is set once per minute whatever the other live fields hold.
- R4: With only the weekday enable set, a tick whose live weekday equals the alarm weekday sets the flag, and any other weekday does not.
- R5: With all six fields enabled, a tick sets the flag only when every field matches. A difference in any one enabled field leaves the flag clear.
- R6: When `tick` = 0, a match has no effect on the flag.
- R7: If the enable mask is 0, the flag is never set.
- R8: Once set, the flag holds through any number of cycles with `status_clr` = 0.
- R9: `status_clr` = 1 clears the flag on the next cycle. If a tick match happens in the same cycle, the set wins and the flag stays 1.
- R10: The write port uses the following addresses:
  - 0: second (6 bits)
  - 1: minute (6 bits)
  - 2: hour (5 bits)
  - 3: date (5 bits)
  - 4: month (4 bits)
  - 5: weekday (3 bits)
  - 6: enable mask. Bit 0 is second, bit 1 minute, bit 2 hour, bit 3 date, bit 4 month, bit 5 weekday.

  Write data is cut to the field width. A write to address 7 changes nothing. A write takes effect for ticks from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle seconds strobe that enables a comparison |
| cur_sec | input | 6 | Live seconds |
| cur_min | input | 6 | Live minutes |
| cur_hr | input | 5 | Live hours |
| cur_date | input | 5 | Live day of month |
| cur_mon | input | 4 | Live month |
| cur_dow | input | 3 | Live weekday |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address (see R10) |
| wr_data | input | 8 | Host write data |
| status_clr | input | 1 | Write-one-to-clear strobe for the flag |
| alarm_flag | output | 1 | Sticky alarm status |

## Verification
The bench targets these corner cases:
- A clear and a match in the same cycle. A design that lets the clear win loses an alarm.
- A matching live time with no tick. A design that ignores the strobe fires many times within one second.
- An empty enable mask. An AND over zero enabled fields is vacuously true, so a careless design fires on every tick.
- A single mismatched field under a full enable. A design that ORs the fields instead of ANDing them fires here.
- Oversized write data and writes to the unused address. A design that does not cut the data to width never matches, and one that decodes address 7 corrupts the alarm setup.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int NF = 6;
    localparam int DW = 8;
    localparam int AW = 3;

    typedef enum logic [AW-1:0] {
        A_SEC  = 3'd0,
        A_MIN  = 3'd1,
        A_HR   = 3'd2,
        A_DATE = 3'd3,
        A_MON  = 3'd4,
        A_DOW  = 3'd5,
        A_EN   = 3'd6
    } alm_addr_e;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hr;
        logic [4:0] date;
        logic [3:0] mon;
        logic [2:0] dow;
    } cal_t;

    typedef logic [NF-1:0][DW-1:0] fld_arr_t;

    function automatic int field_width(input int idx);
        case (idx)
            0, 1:    return 6;
            2, 3:    return 5;
            4:       return 4;
            default: return 3;
        endcase
    endfunction

    function automatic logic [DW-1:0] field_mask(input int idx);
        return DW'((1 << field_width(idx)) - 1);
    endfunction

    function automatic fld_arr_t cal_to_arr(input cal_t c);
        fld_arr_t a;
        a[0] = DW'(c.sec);
        a[1] = DW'(c.min);
        a[2] = DW'(c.hr);
        a[3] = DW'(c.date);
        a[4] = DW'(c.mon);
        a[5] = DW'(c.dow);
        return a;
    endfunction
endpackage

// File: rtl/alm_regs.sv
module alm_regs
    import alm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    output fld_arr_t             alm_vals,
    output logic [NF-1:0]        alm_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            alm_vals <= '0;
            alm_en   <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NF; i++) begin
                if (wr_addr == AW'(i))
                    alm_vals[i] <= wr_data & field_mask(i);
            end
            if (wr_addr == A_EN)
                alm_en <= wr_data[NF-1:0];
        end
    end
endmodule

// File: rtl/alm_cmp.sv
module alm_cmp
    import alm_pkg::*;
(
    input  fld_arr_t       live,
    input  fld_arr_t       alm_vals,
    input  logic [NF-1:0]  alm_en,
    output logic           hit
);
    logic [NF-1:0] fld_ok;

    for (genvar g = 0; g < NF; g++) begin : g_fld
        assign fld_ok[g] = !alm_en[g] ||
                           ((live[g] & field_mask(g)) == alm_vals[g]);
    end

    assign hit = (|alm_en) && (&fld_ok);
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set_req)
            flag <= 1'b1;
        else if (clr_req)
            flag <= 1'b0;
    end
endmodule

// File: rtl/alm_match_top.sv
module alm_match_top
    import alm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic [5:0]  cur_sec,
    input  logic [5:0]  cur_min,
    input  logic [4:0]  cur_hr,
    input  logic [4:0]  cur_date,
    input  logic [3:0]  cur_mon,
    input  logic [2:0]  cur_dow,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        status_clr,
    output logic        alarm_flag
);
    cal_t          now;
    fld_arr_t      live;
    fld_arr_t      alm_vals;
    logic [NF-1:0] en_mask;
    logic          hit;

    assign now  = '{sec: cur_sec, min: cur_min, hr: cur_hr,
                    date: cur_date, mon: cur_mon, dow: cur_dow};
    assign live = cal_to_arr(now);

    alm_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .alm_vals (alm_vals),
        .alm_en   (en_mask)
    );

    alm_cmp u_cmp (
        .live     (live),
        .alm_vals (alm_vals),
        .alm_en   (en_mask),
        .hit      (hit)
    );

    alm_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_req (tick && hit),
        .clr_req (status_clr),
        .flag    (alarm_flag)
    );
endmodule

// File: rtl/alm_match_chk.sv
module alm_match_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       status_clr,
    input logic       alarm_flag,
    input logic       hit,
    input logic [5:0] en_mask
);
    // R1
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> !alarm_flag);

    // R2
    p_set_on_hit_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && hit) |=> alarm_flag);

    // R6
    p_no_tick_no_set_r6: assert property (@(posedge clk) disable iff (rst)
        (!alarm_flag && !tick) |=> !alarm_flag);

    // R7
    p_empty_mask_r7: assert property (@(posedge clk) disable iff (rst)
        (en_mask == 6'd0) |-> !hit);

    // R8
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !status_clr) |=> alarm_flag);

    // R9
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (status_clr && !(tick && hit)) |=> !alarm_flag);
endmodule

bind alm_match_top alm_match_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .status_clr (status_clr),
    .alarm_flag (alarm_flag),
    .hit        (hit),
    .en_mask    (en_mask)
);

// File: tb/sim_alm_match_top.sv
module sim_alm_match_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [5:0] cur_sec = '0;
    logic [5:0] cur_min = '0;
    logic [4:0] cur_hr = '0;
    logic [4:0] cur_date = '0;
    logic [3:0] cur_mon = '0;
    logic [2:0] cur_dow = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       status_clr = 1'b0;
    logic       alarm_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    int m_val [6];
    int m_en;
    bit m_flag;

    always #4 clk = ~clk;

    alm_match_top u0 (
        .clk(clk), .rst(rst), .tick(tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
        .cur_date(cur_date), .cur_mon(cur_mon), .cur_dow(cur_dow),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .status_clr(status_clr), .alarm_flag(alarm_flag)
    );

    function automatic int fw(input int i);
        int w [6] = '{6, 6, 5, 5, 4, 3};
        return w[i];
    endfunction

    function automatic bit ref_hit();
        int live [6];
        live = '{int'(cur_sec), int'(cur_min), int'(cur_hr),
                 int'(cur_date), int'(cur_mon), int'(cur_dow)};
        if (m_en == 0) return 0;
        for (int i = 0; i < 6; i++)
            if (m_en[i] && live[i] != m_val[i]) return 0;
        return 1;
    endfunction

    task automatic check(input bit act, input bit exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: alarm_flag=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_now(input int s, input int mi, input int h,
                           input int d, input int mo, input int w);
        cur_sec = 6'(s); cur_min = 6'(mi); cur_hr = 5'(h);
        cur_date = 5'(d); cur_mon = 4'(mo); cur_dow = 3'(w);
    endtask

    // One cycle: drive at negedge, predict, check at next negedge.
    task automatic cyc(input bit tk, input bit clr, input bit we,
                       input int addr, input int data, input string req);
        tick = tk; status_clr = clr; wr_en = we;
        wr_addr = 3'(addr); wr_data = 8'(data);
        if (tk && ref_hit()) m_flag = 1;
        else if (clr) m_flag = 0;
        if (we) begin
            if (addr < 6) m_val[addr] = data & ((1 << fw(addr)) - 1);
            else if (addr == 6) m_en = data & 8'h3F;
        end
        @(posedge clk);
        @(negedge clk);
        tick = 0; status_clr = 0; wr_en = 0;
        check(alarm_flag, m_flag, req);
    endtask

    task automatic wr(input int addr, input int data, input string req);
        cyc(0, 0, 1, addr, data, req);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        foreach (m_val[i]) m_val[i] = 0;
        m_en = 0; m_flag = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        check(alarm_flag, 1'b0, "R1");
        // R1/R7: reset leaves mask empty, all-zero time must not fire
        set_now(0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, "R7");
        // R3: every minute at second 30
        wr(0, 30, "R10");
        wr(6, 6'b000001, "R10");
        set_now(30, 17, 9, 4, 2, 6);
        cyc(1, 0, 0, 0, 0, "R3");
        cyc(0, 1, 0, 0, 0, "R9");
        set_now(30, 18, 22, 11, 7, 1);
        cyc(1, 0, 0, 0, 0, "R3");
        // R8: sticky over non-matching ticks
        set_now(31, 18, 22, 11, 7, 1);
        for (int k = 0; k < 5; k++) cyc(1, 0, 0, 0, 0, "R8");
        cyc(0, 1, 0, 0, 0, "R9");
        // R6: match without tick
        set_now(30, 19, 0, 1, 1, 0);
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 0, "R6");
        // R4: weekday only
        wr(5, 2, "R10");
        wr(6, 6'b100000, "R10");
        set_now(12, 40, 3, 9, 5, 3);
        cyc(1, 0, 0, 0, 0, "R4");
        set_now(12, 40, 3, 9, 5, 2);
        cyc(1, 0, 0, 0, 0, "R4");
        // R9: clear and match together, set wins
        cyc(1, 1, 0, 0, 0, "R9");
        cyc(0, 1, 0, 0, 0, "R9");
        // R10: unused address ignored
        wr(7, 8'hFF, "R10");
        cyc(1, 0, 0, 0, 0, "R10");
        cyc(0, 1, 0, 0, 0, "R10");
        // R5: exact 05:23:00 on March 21, weekday 4
        wr(0, 0, "R10"); wr(1, 23, "R10"); wr(2, 5, "R10");
        wr(3, 21, "R10"); wr(4, 3, "R10"); wr(5, 4, "R10");
        wr(6, 6'b111111, "R10");
        set_now(0, 23, 5, 20, 3, 4);
        cyc(1, 0, 0, 0, 0, "R5");
        set_now(0, 23, 5, 21, 4, 4);
        cyc(1, 0, 0, 0, 0, "R5");
        set_now(0, 23, 5, 21, 3, 4);
        cyc(1, 0, 0, 0, 0, "R5");
        cyc(0, 1, 0, 0, 0, "R9");
        // R10: oversized data is truncated to 6 bits (0xFF -> 63)
        wr(0, 8'hFF, "R10");
        wr(6, 6'b000001, "R10");
        set_now(63, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, "R10");
        cyc(0, 1, 0, 0, 0, "R9");
        // R7: mask cleared, matching time must not fire
        wr(6, 0, "R7");
        cyc(1, 0, 0, 0, 0, "R7");
        // R2: constrained random mix over small value ranges
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(0, 15);
            set_now($urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(0, 1),
                    $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 2));
            if (r == 0)
                cyc(0, 0, 1, $urandom_range(0, 7), $urandom_range(0, 2), "R2");
            else if (r == 1)
                cyc(0, 0, 1, 6, $urandom_range(0, 63), "R2");
            else
                cyc($urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0, 0, 0, 0, "R2");
        end
        // R1: reset mid-run clears flag and configuration
        wr(6, 6'b000001, "R1"); wr(0, 1, "R1");
        set_now(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, "R1");
        rst = 1;
        @(posedge clk); @(negedge clk);
        rst = 0;
        foreach (m_val[i]) m_val[i] = 0;
        m_en = 0; m_flag = 0;
        check(alarm_flag, 1'b0, "R1");
        cyc(1, 0, 0, 0, 0, "R1");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule